// File: doc/BRIEF.md
# Round-Robin Bus Arbiter with Priority Override

This block decides which of four symmetric requesters owns a shared bus. Each symmetric requester raises its own request line and gets back one bit of a one-hot grant vector. The ranking among symmetric requesters is circular over agent IDs 0, 1, 2 and 3, wrapping back to 0. A register records the ID of the most recent symmetric owner, and the agent just after that ID in circular order ranks first at the next arbitration. The register starts at 3, so agent 0 ranks first after reset. Arbitration runs at a clock edge only when there is no owner, or when the owner has dropped its request. An owner that keeps its request raised keeps the bus. When nobody requests, the last owner stays parked on the bus.

A single priority requester ranks above the symmetric owner. It does not take part in the rotation. While it is requesting, a request-phase enable output is held low, so the symmetric owner cannot start a new transaction. The exception is a lock input: while lock is high, the owner is treated as continuing a locked sequence and may go on issuing.

Top module: `rr_bus_arbiter`

## Requirements
- R1: While reset is asserted and after its release until the first request is registered, `sym_gnt` is 4'b0000, `owner_id` is 3 and `req_phase_en` is 0.
- R2: When arbitration takes place, the winner is the first requesting agent found by starting at `owner_id`+1 and moving upward modulo 4. The current `owner_id` therefore ranks last. After reset, agent 0 ranks first.
- R3: A winner appears on `sym_gnt` (bit n is agent n) and on `owner_id` one clock edge after its request is sampled. From then on, `owner_id` holds that winner as the rotating ID.
- R4: While the current owner's request bit is high at a clock edge, `sym_gnt` and `owner_id` stay unchanged, whatever the other request bits are.
- R5: When no symmetric request is high, `sym_gnt` and `owner_id` keep their values, so the last owner stays parked.
- R6: `sym_gnt` has at most one bit set. When a bit is set, its index equals `owner_id`.
- R7: `req_phase_en` is 1 exactly when a grant is held and either `prio_req` is 0 or `lock_in` is 1. It follows `prio_req` and `lock_in` in the same cycle, without waiting for a clock edge.
- R8: `prio_req` and `lock_in` have no effect on `sym_gnt` or `owner_id`.
- R9: A grant bit that becomes newly set always belongs to an agent whose request was high at the edge where the grant changed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; everything updates on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sym_req | input | 4 | Request lines of the symmetric agents, bit n = agent n |
| prio_req | input | 1 | Request from the priority agent |
| lock_in | input | 1 | High while a bus-locked sequence is in progress |
| sym_gnt | output | 4 | One-hot grant to the symmetric owner, all zero when nobody owns |
| owner_id | output | 2 | Rotating ID: agent ID of the most recent symmetric owner |
| req_phase_en | output | 1 | Symmetric owner may start a new request phase |

## Verification
On every cycle, the assertions check four things: the grant is one-hot or empty and agrees with `owner_id`; an owner that keeps requesting is never displaced; the state is frozen when no request is high; and a new grant only ever goes to an agent that was requesting. They also check that the priority request without lock always holds the request-phase enable low. Only the bench scenarios can show the exact circular ranking, because a property cannot cheaply state the expected winner. These scenarios cover the first grant to agent 0 after reset, each step of the rotation including the wrap from 3 to 0, and the choice made from a parked owner. They also show that the priority request and lock leave the rotation untouched while switching the enable in the same cycle.

// File: rtl/rr_arb_pkg.sv
package rr_arb_pkg;
    // Number of symmetric agents taking part in the rotation (power of two).
    parameter int unsigned RR_AGENTS_DEF = 4;
endpackage

// File: rtl/rr_arb_pick.sv
// Combinational circular search: first requester after last_id wins.
module rr_arb_pick #(
    parameter int unsigned NUM_AGENTS = 4,
    localparam int unsigned ID_W = $clog2(NUM_AGENTS)
) (
    input  logic [NUM_AGENTS-1:0] req,
    input  logic [ID_W-1:0]       last_id,
    output logic                  found,
    output logic [ID_W-1:0]       pick_id
);
    logic [ID_W-1:0] cand;

    always_comb begin
        found   = 1'b0;
        pick_id = last_id;
        cand    = last_id;
        // Walk from the farthest offset to the nearest; the nearest requester
        // overwrites the others and so wins. Offset NUM_AGENTS wraps to last_id.
        for (int i = NUM_AGENTS - 1; i >= 0; i--) begin
            cand = last_id + ID_W'(i + 1);
            if (req[cand]) begin
                found   = 1'b1;
                pick_id = cand;
            end
        end
    end
endmodule

// File: rtl/rr_arb_gate.sv
// Request-phase gating by the priority agent, with the locked-sequence exception.
module rr_arb_gate (
    input  logic owner_present,
    input  logic prio_req,
    input  logic lock_in,
    output logic req_phase_en
);
    logic prio_blocks;

    always_comb begin
        prio_blocks  = prio_req & ~lock_in;
        req_phase_en = owner_present & ~prio_blocks;
    end
endmodule

// File: rtl/rr_bus_arbiter.sv
module rr_bus_arbiter #(
    parameter int unsigned NUM_AGENTS = rr_arb_pkg::RR_AGENTS_DEF,
    localparam int unsigned ID_W = $clog2(NUM_AGENTS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_AGENTS-1:0] sym_req,
    input  logic                  prio_req,
    input  logic                  lock_in,
    output logic [NUM_AGENTS-1:0] sym_gnt,
    output logic [ID_W-1:0]       owner_id,
    output logic                  req_phase_en
);
    typedef struct packed {
        logic            own_vld;
        logic [ID_W-1:0] rot_id;
    } arb_state_t;

    localparam arb_state_t ST_RESET = '{own_vld: 1'b0, rot_id: ID_W'(NUM_AGENTS - 1)};

    arb_state_t st_d, st_q;
    logic       pick_found;
    logic [ID_W-1:0] pick_id;
    logic       owner_holds;

    rr_arb_pick #(.NUM_AGENTS(NUM_AGENTS)) u_pick (
        .req     (sym_req),
        .last_id (st_q.rot_id),
        .found   (pick_found),
        .pick_id (pick_id)
    );

    always_comb begin
        st_d        = st_q;
        owner_holds = st_q.own_vld & sym_req[st_q.rot_id];
        if (!owner_holds && pick_found) begin
            st_d.own_vld = 1'b1;
            st_d.rot_id  = pick_id;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < NUM_AGENTS; g++) begin : g_gnt
        assign sym_gnt[g] = st_q.own_vld && (st_q.rot_id == ID_W'(g));
    end

    assign owner_id = st_q.rot_id;

    rr_arb_gate u_gate (
        .owner_present (st_q.own_vld),
        .prio_req      (prio_req),
        .lock_in       (lock_in),
        .req_phase_en  (req_phase_en)
    );
endmodule

// File: rtl/rr_bus_arbiter_chk.sv
module rr_bus_arbiter_chk #(
    parameter int unsigned NUM_AGENTS = 4,
    localparam int unsigned ID_W = $clog2(NUM_AGENTS)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NUM_AGENTS-1:0] sym_req,
    input logic                  prio_req,
    input logic                  lock_in,
    input logic [NUM_AGENTS-1:0] sym_gnt,
    input logic [ID_W-1:0]       owner_id,
    input logic                  req_phase_en
);
    // R6
    gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sym_gnt));

    // R6
    gnt_matches_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_gnt != '0) |-> sym_gnt[owner_id]);

    // R4
    owner_keeps_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((sym_gnt != '0) && sym_req[owner_id]) |=> ($stable(sym_gnt) && $stable(owner_id)));

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_req == '0) |=> ($stable(sym_gnt) && $stable(owner_id)));

    // R9
    new_gnt_was_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sym_gnt) && (sym_gnt != '0)) |-> (($past(sym_req) & sym_gnt) != '0));

    // R7
    prio_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prio_req && !lock_in) |-> !req_phase_en);

    // R7
    no_owner_no_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_gnt == '0) |-> !req_phase_en);
endmodule

bind rr_bus_arbiter rr_bus_arbiter_chk #(.NUM_AGENTS(NUM_AGENTS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sym_req      (sym_req),
    .prio_req     (prio_req),
    .lock_in      (lock_in),
    .sym_gnt      (sym_gnt),
    .owner_id     (owner_id),
    .req_phase_en (req_phase_en)
);

// File: tb/rr_bus_arbiter_bench.sv
module rr_bus_arbiter_bench;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] sym_req = '0;
    logic       prio_req = 1'b0;
    logic       lock_in = 1'b0;
    logic [3:0] sym_gnt;
    logic [1:0] owner_id;
    logic       req_phase_en;

    int checks = 0;
    int errors = 0;

    rr_bus_arbiter u_rr_bus_arbiter (
        .clk          (clk),
        .rst_n        (rst_n),
        .sym_req      (sym_req),
        .prio_req     (prio_req),
        .lock_in      (lock_in),
        .sym_gnt      (sym_gnt),
        .owner_id     (owner_id),
        .req_phase_en (req_phase_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic expect_out(input string tag, input logic [3:0] g,
                              input logic [1:0] id, input logic en);
        checks++;
        if (sym_gnt !== g || owner_id !== id || req_phase_en !== en) begin
            errors++;
            $display("FAIL %s: gnt=%b id=%0d en=%b expected gnt=%b id=%0d en=%b",
                     tag, sym_gnt, owner_id, req_phase_en, g, id, en);
        end
    endtask

    // Drive at the falling edge, let one rising edge register, sample at the next fall.
    task automatic step(input logic [3:0] r);
        sym_req = r;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        expect_out("R1 in reset", 4'b0000, 2'd3, 1'b0);
        rst_n = 1'b1;
        step(4'b0000);
        expect_out("R1 after release idle", 4'b0000, 2'd3, 1'b0);
    endtask

    task automatic t_first_grant();
        step(4'b1111);
        expect_out("R2 R3 first grant to agent 0", 4'b0001, 2'd0, 1'b1);
    endtask

    task automatic t_hold();
        step(4'b1111);
        expect_out("R4 owner 0 keeps bus", 4'b0001, 2'd0, 1'b1);
        step(4'b1111);
        expect_out("R4 owner 0 still holds", 4'b0001, 2'd0, 1'b1);
    endtask

    task automatic t_rotate();
        step(4'b1110);
        expect_out("R2 rotate to 1", 4'b0010, 2'd1, 1'b1);
        step(4'b1101);
        expect_out("R2 rotate to 2", 4'b0100, 2'd2, 1'b1);
        step(4'b1011);
        expect_out("R2 rotate to 3", 4'b1000, 2'd3, 1'b1);
        step(4'b0111);
        expect_out("R2 wrap to 0", 4'b0001, 2'd0, 1'b1);
        step(4'b1100);
        expect_out("R2 skip idle agent 1, pick 2", 4'b0100, 2'd2, 1'b1);
        step(4'b0011);
        expect_out("R2 skip 3, wrap to 0", 4'b0001, 2'd0, 1'b1);
    endtask

    task automatic t_idle();
        step(4'b0000);
        expect_out("R5 parked on 0", 4'b0001, 2'd0, 1'b1);
        step(4'b0000);
        expect_out("R5 still parked", 4'b0001, 2'd0, 1'b1);
    endtask

    task automatic t_parked();
        step(4'b1001);
        expect_out("R4 parked owner re-requests and keeps", 4'b0001, 2'd0, 1'b1);
        step(4'b1000);
        expect_out("R3 R9 owner_id moves to 3", 4'b1000, 2'd3, 1'b1);
    endtask

    task automatic t_priority();
        prio_req = 1'b1;
        #1;
        expect_out("R7 prio blocks same cycle", 4'b1000, 2'd3, 1'b0);
        step(4'b1000);
        expect_out("R8 prio leaves grant", 4'b1000, 2'd3, 1'b0);
        step(4'b0100);
        expect_out("R8 rotation continues under prio", 4'b0100, 2'd2, 1'b0);
        lock_in = 1'b1;
        #1;
        expect_out("R7 lock lets owner issue", 4'b0100, 2'd2, 1'b1);
        step(4'b0100);
        expect_out("R8 lock leaves grant", 4'b0100, 2'd2, 1'b1);
        prio_req = 1'b0;
        lock_in  = 1'b0;
        #1;
        expect_out("R7 enable back without prio", 4'b0100, 2'd2, 1'b1);
    endtask

    initial begin
        t_reset();
        t_first_grant();
        t_hold();
        t_rotate();
        t_idle();
        t_parked();
        t_priority();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (2000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule